// File: doc/BRIEF.md
# Serial Flash Security Register Responder

This block is the slave side of a single-bit SPI serial flash, trimmed down to the one-time-programmable security register area. The host drives chip select, serial clock and data in mode 0. Input bits are taken on rising clock edges and output bits change on falling clock edges. The block decodes a read opcode and a program opcode, then takes a 24-bit address. From that address it picks one of a set of small registers and a starting byte offset inside it. It then either streams stored bytes back to the host or merges incoming bytes into storage.

The serial lines are oversampled by a fast system clock. The block finds clock edges by comparing the current serial clock with its value one system cycle earlier. The data output comes with a separate drive enable, so the pad or the enclosing chip can place the line in high impedance whenever the enable is low. The storage is modelled on chip as erased bytes that read 0xFF after reset.

Top module: `secreg_responder`

## Requirements
- R1: Opcode 0x48 starts a read and opcode 0x42 starts a program. Any other opcode makes the block ignore the rest of the transfer: `miso_oe` stays low and storage is unchanged.
- R2: After the opcode come 24 address bits, MSB first, each sampled on a rising `sck`. Address bits 15:12 equal to 1, 2 or 3 select storage register 1, 2 or 3. The low `OFFSET_W` bits give the byte offset.
- R3: A read has one dummy byte after the address. `miso_oe` stays low through the opcode, the address and the dummy byte. It goes high at the first falling `sck` after the last dummy bit. Data is sent MSB first, and `miso` changes only after a falling `sck`.
- R4: During a read the offset increases by one after each byte sent. After offset 2^`OFFSET_W`-1 the next byte comes from offset 0 of the same register, and the read continues until `cs_n` rises.
- R5: An address is invalid if bits 23:16 are nonzero, if bits 11:`OFFSET_W` are nonzero, or if bits 15:12 select no register. A read from an invalid address returns 0xFF bytes, and a program to one changes no stored byte.
- R6: Program data bytes arrive MSB first. Each stored byte becomes the AND of its old value and the received byte. The offset advances within an aligned page of 2^`PAGE_W` bytes and wraps to the start of that page.
- R7: A program byte is written only if all 8 of its bits were sampled before `cs_n` rises. A partial byte is dropped.
- R8: `cs_n` high aborts any command, resets the bit count and drives `miso_oe` low on the next clock. A new command can follow immediately.
- R9: After reset every stored byte reads 0xFF and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for `miso`; low means high impedance |

## Verification
The bench builds the block with `OFFSET_W` = 6, `PAGE_W` = 4 and three registers. With these values the read wrap from offset 63 to 0 and the 16-byte page wrap of a program can be reached with a few bytes. Bits 11:6 of the address must then be zero, so a set bit 10 acts as a stray high offset bit and tests the invalid-address rule. The decode, the AND merge, the dropped partial byte and the abort on `cs_n` all behave the same as at the default sizes.

// File: rtl/secreg_responder.sv
module secreg_responder #(
  parameter int OFFSET_W = 10,
  parameter int PAGE_W   = 8,
  parameter int NUM_REGS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << OFFSET_W;
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int IDX_W = SEL_W + OFFSET_W;
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [OFFSET_W-1:0] PMASK = OFFSET_W'((1 << PAGE_W) - 1);
  localparam logic [7:0] OP_READ = 8'h48;
  localparam logic [7:0] OP_PROG = 8'h42;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_RDATA, S_PDATA, S_SKIP} state_t;

  logic [7:0]          mem [SLOTS];
  state_t              state;
  logic                is_read, hit, sck_q;
  logic [4:0]          cnt;
  logic [6:0]          in_sh;
  logic [7:0]          out_sh;
  logic [22:0]         addr;
  logic [OFFSET_W-1:0] off;
  logic [SEL_W-1:0]    sel;

  wire rise = !cs_n && sck && !sck_q;
  wire fall = !cs_n && !sck && sck_q;

  wire [7:0]  in_byte   = {in_sh, mosi};
  wire [23:0] addr_full = {addr, mosi};
  wire [3:0]  addr_reg  = addr_full[15:12];
  wire addr_ok = (addr_full[23:16] == 8'h00) && ((addr_full[11:0] >> OFFSET_W) == 12'd0) &&
                 (addr_reg != 4'd0) && (addr_reg <= 4'(NUM_REGS));

  wire [OFFSET_W-1:0] off_next  = off + OFFSET_W'(1);
  wire [OFFSET_W-1:0] page_next = (off & ~PMASK) | (off_next & PMASK);
  wire [7:0] cur_byte  = hit ? mem[{sel, off}]      : 8'hFF;
  wire [7:0] next_byte = hit ? mem[{sel, off_next}] : 8'hFF;

  assign miso = out_sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_CMD;
      is_read <= 1'b0;
      hit     <= 1'b0;
      sck_q   <= 1'b0;
      cnt     <= '0;
      in_sh   <= '0;
      out_sh  <= 8'hFF;
      addr    <= '0;
      off     <= '0;
      sel     <= '0;
      miso_oe <= 1'b0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= 8'hFF;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        state   <= S_CMD;
        cnt     <= '0;
        miso_oe <= 1'b0;
      end else if (rise) begin
        in_sh <= in_byte[6:0];
        case (state)
          S_CMD: begin
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt     <= '0;
              is_read <= (in_byte == OP_READ);
              state   <= (in_byte == OP_READ || in_byte == OP_PROG) ? S_ADDR : S_SKIP;
            end
          end
          S_ADDR: begin
            cnt  <= cnt + 5'd1;
            addr <= addr_full[22:0];
            if (cnt == 5'd23) begin
              cnt   <= '0;
              hit   <= addr_ok;
              sel   <= SEL_W'(addr_reg - 4'd1);
              off   <= addr_full[OFFSET_W-1:0];
              state <= is_read ? S_DUMMY : S_PDATA;
            end
          end
          S_DUMMY: begin
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt    <= '0;
              out_sh <= cur_byte;
              state  <= S_RDATA;
            end
          end
          S_PDATA: begin
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (hit) mem[{sel, off}] <= mem[{sel, off}] & in_byte;
              off <= page_next;
            end
          end
          default: ;
        endcase
      end else if (fall && state == S_RDATA) begin
        if (!miso_oe) begin
          miso_oe <= 1'b1;
        end else if (cnt == 5'd7) begin
          cnt    <= '0;
          off    <= off_next;
          out_sh <= next_byte;
        end else begin
          cnt    <= cnt + 5'd1;
          out_sh <= {out_sh[6:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/secreg_responder_sva.sv
module secreg_responder_sva (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic miso,
  input logic miso_oe
);
  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !miso_oe); // R8

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !$past(cs_n)); // R8

  AST_OE_RISES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> ($past(sck, 2) && !$past(sck, 1))); // R3

  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(miso_oe) && miso_oe && !$stable(miso)) |-> ($past(sck, 2) && !$past(sck, 1))); // R3

  AST_OE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(miso_oe)); // R9
endmodule

bind secreg_responder secreg_responder_sva i_sva (.*);

// File: tb/test_secreg_responder.sv
module test_secreg_responder;
  localparam int OW = 6;
  localparam int PW = 4;
  localparam int NR = 3;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;

  always #2 clk = ~clk;

  secreg_responder #(.OFFSET_W(OW), .PAGE_W(PW), .NUM_REGS(NR)) i_secreg_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rd [4];
  bit oe_early, oe_data_ok;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] ad(input int r, input int o);
    return {8'h00, 4'(r), 12'(o)};
  endfunction

  task automatic xbyte(input logic [7:0] tx, input int nbits,
                       output logic [7:0] rx, output bit oe_any, output bit oe_all);
    oe_any = 0; oe_all = 1; rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      if (miso_oe) oe_any = 1; else oe_all = 0;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_begin;
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_end;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_head(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r; bit any, all;
    xbyte(op, 8, r, any, all); if (any) oe_early = 1;
    for (int k = 2; k >= 0; k--) begin
      xbyte(a[k*8 +: 8], 8, r, any, all); if (any) oe_early = 1;
    end
  endtask

  task automatic sread(input logic [23:0] a, input int n);
    logic [7:0] r; bit any, all;
    oe_early = 0; oe_data_ok = 1;
    cs_begin;
    send_head(8'h48, a);
    xbyte(8'h00, 8, r, any, all); if (any) oe_early = 1;
    for (int k = 0; k < n; k++) begin
      xbyte(8'hFF, 8, rd[k], any, all);
      if (!all) oe_data_ok = 0;
    end
    cs_end;
  endtask

  task automatic sprog(input logic [7:0] op, input logic [23:0] a, input int n,
                       input logic [7:0] b0, input logic [7:0] b1, input int tail_bits);
    logic [7:0] r; bit any, all;
    oe_early = 0;
    cs_begin;
    send_head(op, a);
    if (n > 0) begin xbyte(b0, 8, r, any, all); if (any) oe_early = 1; end
    if (n > 1) begin xbyte(b1, 8, r, any, all); if (any) oe_early = 1; end
    if (tail_bits > 0) begin xbyte(8'h00, tail_bits, r, any, all); if (any) oe_early = 1; end
    cs_end;
  endtask

  task automatic t_reset;
    chk("R9 oe low after reset", 32'(miso_oe), 0);
    sread(ad(1, 0), 2);
    chk("R9 erased byte 0", 32'(rd[0]), 32'hFF);
    chk("R9 erased byte 1", 32'(rd[1]), 32'hFF);
    chk("R3 oe low through header and dummy", 32'(oe_early), 0);
    chk("R3 oe high during data", 32'(oe_data_ok), 1);
  endtask

  task automatic t_program;
    sprog(8'h42, ad(1, 5), 2, 8'hA5, 8'h3C, 0);
    chk("R6 program keeps oe low", 32'(oe_early), 0);
    sread(ad(1, 5), 2);
    chk("R6 first programmed byte", 32'(rd[0]), 32'hA5);
    chk("R4 second byte from next offset", 32'(rd[1]), 32'h3C);
    chk("R3 oe timing on read", 32'({oe_early, oe_data_ok}), 32'b01);
  endtask

  task automatic t_and_merge;
    sprog(8'h42, ad(1, 5), 1, 8'hF0, 8'h00, 0);
    sread(ad(1, 5), 1);
    chk("R6 AND merge", 32'(rd[0]), 32'hA0);
  endtask

  task automatic t_reg_select;
    sprog(8'h42, ad(2, 5), 1, 8'h11, 8'h00, 0);
    sread(ad(2, 5), 1);
    chk("R2 register 2 written", 32'(rd[0]), 32'h11);
    sread(ad(3, 5), 1);
    chk("R2 register 3 untouched", 32'(rd[0]), 32'hFF);
    sread(ad(1, 5), 1);
    chk("R2 register 1 untouched", 32'(rd[0]), 32'hA0);
  endtask

  task automatic t_invalid;
    sread(ad(0, 5), 1);
    chk("R5 select 0 reads FF", 32'(rd[0]), 32'hFF);
    sread(ad(4, 5), 1);
    chk("R5 select 4 reads FF", 32'(rd[0]), 32'hFF);
    sprog(8'h42, 24'h011005, 1, 8'h00, 8'h00, 0);
    sprog(8'h42, 24'h001405, 1, 8'h00, 8'h00, 0);
    sprog(8'h42, 24'h004005, 1, 8'h00, 8'h00, 0);
    sread(ad(1, 5), 1);
    chk("R5 invalid programs ignored", 32'(rd[0]), 32'hA0);
    sread(24'h001405, 1);
    chk("R5 stray offset bit reads FF", 32'(rd[0]), 32'hFF);
  endtask

  task automatic t_partial;
    sprog(8'h42, ad(1, 8), 1, 8'h0F, 8'h00, 5);
    sread(ad(1, 8), 2);
    chk("R7 full byte committed", 32'(rd[0]), 32'h0F);
    chk("R7 partial byte dropped", 32'(rd[1]), 32'hFF);
  endtask

  task automatic t_page_wrap;
    sprog(8'h42, ad(3, 15), 2, 8'h12, 8'h34, 0);
    sread(ad(3, 15), 2);
    chk("R6 last byte of page", 32'(rd[0]), 32'h12);
    chk("R6 offset 16 not written", 32'(rd[1]), 32'hFF);
    sread(ad(3, 0), 1);
    chk("R6 wrapped to page start", 32'(rd[0]), 32'h34);
  endtask

  task automatic t_read_wrap;
    sprog(8'h42, ad(2, 63), 1, 8'h77, 8'h00, 0);
    sprog(8'h42, ad(2, 0), 1, 8'h5A, 8'h00, 0);
    sread(ad(2, 63), 3);
    chk("R4 last offset", 32'(rd[0]), 32'h77);
    chk("R4 wrap to offset 0", 32'(rd[1]), 32'h5A);
    chk("R4 continues at offset 1", 32'(rd[2]), 32'hFF);
  endtask

  task automatic t_bad_opcode;
    sprog(8'h03, ad(1, 9), 1, 8'h00, 8'h00, 0);
    chk("R1 unknown opcode keeps oe low", 32'(oe_early), 0);
    sprog(8'h0B, ad(1, 9), 2, 8'h00, 8'h00, 0);
    chk("R1 second unknown opcode keeps oe low", 32'(oe_early), 0);
    sread(ad(1, 9), 1);
    chk("R1 unknown opcode wrote nothing", 32'(rd[0]), 32'hFF);
  endtask

  task automatic t_abort;
    logic [7:0] r; bit any, all;
    cs_begin;
    send_head(8'h48, ad(1, 5));
    xbyte(8'h00, 8, r, any, all);
    xbyte(8'hFF, 4, r, any, all);
    chk("R8 oe high before abort", 32'(any), 1);
    chk("R3 first nibble MSB first", 32'(r[7:4]), 32'hA);
    @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 oe low after abort", 32'(miso_oe), 0);
    repeat (2) @(negedge clk);
    sread(ad(1, 5), 1);
    chk("R8 fresh command after abort", 32'(rd[0]), 32'hA0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_program;
    t_and_merge;
    t_reg_select;
    t_invalid;
    t_partial;
    t_page_wrap;
    t_read_wrap;
    t_bad_opcode;
    t_abort;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule